// File: doc/BRIEF.md
# Mixed-Page Set-Associative TLB

This block caches address translations produced by a page-table walker. Its array holds 64 sets of 8 ways. Each entry records a virtual page number, a physical page number and a page-size code. The sizes are 4 KiB, 64 KiB and 1 MiB, and all three share the one array. A lookup presents a virtual address and receives a registered hit flag and a physical address one cycle later. When a lookup misses, the walker installs its result through the fill port. The fill goes into the set selected by the filled virtual address.

The set index always comes from virtual address bits [17:12], whatever the page size. A 4 KiB translation therefore lives in exactly one set. A 64 KiB translation can end up in any of the 16 sets its page spans. A 1 MiB translation can end up in any of the 64 sets. Each way compares only the tag bits that are significant for the page size it has stored.

Software maintains the cache with two commands, both decoded from register writes:
- A global flush clears every entry.
- A per-address invalidate takes a 4 KiB-aligned address with bit 0 as its marker. It clears every entry in the addressed set whose size-masked tag covers that address.

To clear a large page completely, software steps the invalidate across the page in 4 KiB increments.

Top module: `mixed_page_tlb`

## Requirements
- R1: A lookup request in cycle N yields `resp_valid_o` high in cycle N+1 only. After reset every entry is invalid, so every lookup misses.
- R2: `fill_size_i` codes are 0 = 4 KiB, 1 = 64 KiB and 2 = 1 MiB. A fill is stored in set `fill_va_i[17:12]`. A 4 KiB entry hits only for lookups with identical `va[31:12]`, and returns `{pa[31:12], va[11:0]}`.
- R3: A 64 KiB entry hits for any lookup in its set whose `va[31:16]` matches, and returns `{pa[31:16], va[15:0]}`. A lookup of the same page that indexes a different set misses.
- R4: A 1 MiB entry hits for any lookup in its set whose `va[31:20]` matches, and returns `{pa[31:20], va[19:0]}`.
- R5: A lookup whose set holds no matching valid entry returns `resp_hit_o` low. `resp_hit_o` is never high without `resp_valid_o`.
- R6: `flush_all_i` invalidates every entry in one cycle. A fill presented in the same cycle is dropped.
- R7: An invalidate with `inv_addr_i[0]` = 1 clears, in set `inv_addr_i[17:12]`, every valid entry whose tag, masked by that entry's size, matches `inv_addr_i[31:12]`. All other entries are left valid. Sixteen such commands stepped by 4 KiB clear a 64 KiB entry.
- R8: An invalidate with `inv_addr_i[0]` = 0 has no effect.
- R9: A marked invalidate to the same set as a fill in the same cycle wins, and the fill is dropped. A fill to another set still installs. A fill with size code 3 is dropped.
- R10: A fill goes to the lowest-numbered invalid way of its set. With all ways valid, it replaces the way chosen by a binary-tree pseudo-LRU:
  - Every lookup hit or fill points each tree node on the touched way's path away from that way.
  - The victim is reached by following the node pointers from the root, where 0 means the lower half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lookup_valid_i | input | 1 | Lookup request strobe |
| lookup_va_i | input | 32 | Lookup virtual address |
| resp_valid_o | output | 1 | Registered lookup response valid |
| resp_hit_o | output | 1 | Registered hit flag |
| resp_pa_o | output | 32 | Registered translated address |
| fill_valid_i | input | 1 | Fill strobe from the walker |
| fill_va_i | input | 32 | Virtual address of the fill |
| fill_pa_i | input | 32 | Physical page address of the fill |
| fill_size_i | input | 2 | Page-size code of the fill |
| flush_all_i | input | 1 | Invalidate-all command |
| inv_valid_i | input | 1 | Per-address invalidate strobe |
| inv_addr_i | input | 32 | Invalidate address; bit 0 is the marker |

## Verification
The bench targets the following corner cases:
- **Large-page set placement.** It probes a 64 KiB page from a set other than the one it was filled into. A design that replicated fills, or indexed by page-aligned bits, would hit there.
- **Size-masked invalidate.** It invalidates a 1 MiB entry through a different 4 KiB address of the same section that falls in the same set. It also sends an invalidate for the same section through another set, which must leave the entry alone. A design that compared unmasked tags, or ignored the set, fails one of these.
- **Clearing every match in a set.** It places two overlapping entries in one set and checks that a single command removes both while leaving an unrelated entry in place. A design that cleared only the first match keeps a stale translation.
- **Same-cycle collisions.** It exercises invalidate against fill and flush against fill in the same cycle. A design with the wrong priority would install a fill that must be lost.
- **Replacement order.** It fills eight ways, hits one of them, and then predicts the exact victim of the next fill. A design with a different victim choice evicts the wrong translation.

// File: rtl/mtlb_pkg.sv
package mtlb_pkg;
  parameter int unsigned VA_W     = 32;
  parameter int unsigned PA_W     = 32;
  parameter int unsigned PG_ORDER = 12;
  parameter int unsigned LP_ORDER = 16;
  parameter int unsigned SC_ORDER = 20;

  localparam int unsigned VPN_W = VA_W - PG_ORDER;
  localparam int unsigned PPN_W = PA_W - PG_ORDER;
  localparam int unsigned LP_SH = LP_ORDER - PG_ORDER;
  localparam int unsigned SC_SH = SC_ORDER - PG_ORDER;

  typedef enum logic [1:0] {
    PG_4K   = 2'd0,
    PG_64K  = 2'd1,
    PG_1M   = 2'd2,
    PG_RSVD = 2'd3
  } pg_size_e;

  typedef struct packed {
    pg_size_e           sz;
    logic [VPN_W-1:0]   vpn;
    logic [PPN_W-1:0]   ppn;
  } tlb_ent_t;

  // significant vpn bits for a given page size
  function automatic logic [VPN_W-1:0] vpn_mask(pg_size_e sz);
    case (sz)
      PG_64K:  return {VPN_W{1'b1}} << LP_SH;
      PG_1M:   return {VPN_W{1'b1}} << SC_SH;
      default: return {VPN_W{1'b1}};
    endcase
  endfunction

  function automatic logic [PA_W-1:0] make_pa(tlb_ent_t e, logic [VA_W-1:0] va);
    logic [PA_W-1:0] hi_mask;
    logic [PA_W-1:0] base;
    case (e.sz)
      PG_64K:  hi_mask = {PA_W{1'b1}} << LP_ORDER;
      PG_1M:   hi_mask = {PA_W{1'b1}} << SC_ORDER;
      default: hi_mask = {PA_W{1'b1}} << PG_ORDER;
    endcase
    base = {e.ppn, {PG_ORDER{1'b0}}};
    return (base & hi_mask) | (PA_W'(va) & ~hi_mask);
  endfunction
endpackage

// File: rtl/mtlb_way_cmp.sv
module mtlb_way_cmp
  import mtlb_pkg::*;
(
  input  logic             vld_i,
  input  tlb_ent_t         ent_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic             match_o
);
  assign match_o = vld_i && (((ent_i.vpn ^ vpn_i) & vpn_mask(ent_i.sz)) == '0);
endmodule

// File: rtl/mtlb_plru.sv
module mtlb_plru #(
  parameter int unsigned SETS = 64,
  parameter int unsigned WAYS = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    a_en_i,
  input  logic [$clog2(SETS)-1:0] a_set_i,
  input  logic [$clog2(WAYS)-1:0] a_way_i,
  input  logic                    b_en_i,
  input  logic [$clog2(SETS)-1:0] b_set_i,
  input  logic [$clog2(WAYS)-1:0] b_way_i,
  input  logic [$clog2(SETS)-1:0] vic_set_i,
  output logic [$clog2(WAYS)-1:0] vic_way_o
);
  localparam int unsigned WAY_W   = $clog2(WAYS);
  localparam int unsigned NODES   = WAYS - 1;
  localparam int unsigned NODE_IW = $clog2(NODES);

  logic [NODES-1:0] plru_q [SETS];
  logic [NODES-1:0] a_next, b_base, b_next;

  function automatic logic [NODES-1:0] touch(logic [NODES-1:0] t, logic [WAY_W-1:0] w);
    logic [WAY_W:0] n;
    logic           d;
    n = '0;
    for (int l = 0; l < WAY_W; l++) begin
      d = w[WAY_W-1-l];
      t[n[NODE_IW-1:0]] = ~d;
      n = (n << 1) + (WAY_W+1)'(1) + {{WAY_W{1'b0}}, d};
    end
    return t;
  endfunction

  function automatic logic [WAY_W-1:0] victim(logic [NODES-1:0] t);
    logic [WAY_W:0] n;
    n = '0;
    for (int l = 0; l < WAY_W; l++)
      n = (n << 1) + (WAY_W+1)'(1) + {{WAY_W{1'b0}}, t[n[NODE_IW-1:0]]};
    return WAY_W'(n - (WAY_W+1)'(WAYS-1));
  endfunction

  always_comb begin
    a_next = touch(plru_q[a_set_i], a_way_i);
    b_base = (a_en_i && a_set_i == b_set_i) ? a_next : plru_q[b_set_i];
    b_next = touch(b_base, b_way_i);
  end

  assign vic_way_o = victim(plru_q[vic_set_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) plru_q[s] <= '0;
    end else begin
      if (a_en_i) plru_q[a_set_i] <= a_next;
      if (b_en_i) plru_q[b_set_i] <= b_next;
    end
  end
endmodule

// File: rtl/mixed_page_tlb.sv
module mixed_page_tlb
  import mtlb_pkg::*;
#(
  parameter int unsigned SETS = 64,
  parameter int unsigned WAYS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lookup_valid_i,
  input  logic [VA_W-1:0] lookup_va_i,
  output logic            resp_valid_o,
  output logic            resp_hit_o,
  output logic [PA_W-1:0] resp_pa_o,
  input  logic            fill_valid_i,
  input  logic [VA_W-1:0] fill_va_i,
  input  logic [PA_W-1:0] fill_pa_i,
  input  logic [1:0]      fill_size_i,
  input  logic            flush_all_i,
  input  logic            inv_valid_i,
  input  logic [VA_W-1:0] inv_addr_i
);
  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned WAY_W = $clog2(WAYS);

  logic [WAYS-1:0] vld_q [SETS];
  tlb_ent_t        ent_q [SETS][WAYS];

  logic [SET_W-1:0] lk_set, fill_set, inv_set;
  logic [VPN_W-1:0] lk_vpn, inv_vpn;
  assign lk_set   = lookup_va_i[PG_ORDER +: SET_W];
  assign fill_set = fill_va_i[PG_ORDER +: SET_W];
  assign inv_set  = inv_addr_i[PG_ORDER +: SET_W];
  assign lk_vpn   = lookup_va_i[VA_W-1:PG_ORDER];
  assign inv_vpn  = inv_addr_i[VA_W-1:PG_ORDER];

  logic unused_bits;
  assign unused_bits = ^{fill_va_i[PG_ORDER-1:0], fill_pa_i[PG_ORDER-1:0],
                         inv_addr_i[PG_ORDER-1:1]};

  // per-way tag compare for the lookup and the invalidate ports
  logic [WAYS-1:0] lk_vec, inv_vec;
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    mtlb_way_cmp u_lk_cmp (
      .vld_i  (vld_q[lk_set][w]),
      .ent_i  (ent_q[lk_set][w]),
      .vpn_i  (lk_vpn),
      .match_o(lk_vec[w])
    );
    mtlb_way_cmp u_inv_cmp (
      .vld_i  (vld_q[inv_set][w]),
      .ent_i  (ent_q[inv_set][w]),
      .vpn_i  (inv_vpn),
      .match_o(inv_vec[w])
    );
  end

  logic             lk_any;
  logic [WAY_W-1:0] lk_way;
  always_comb begin
    lk_any = 1'b0;
    lk_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (lk_vec[w]) begin
        lk_any = 1'b1;
        lk_way = WAY_W'(w);
      end
    end
  end

  // fill arbitration: flush and same-set invalidate win over a fill
  logic inv_cmd, fill_ok, fill_wr;
  assign inv_cmd = inv_valid_i && inv_addr_i[0];
  assign fill_ok = fill_valid_i && (pg_size_e'(fill_size_i) != PG_RSVD);
  assign fill_wr = fill_ok && !flush_all_i && !(inv_cmd && inv_set == fill_set);

  logic             has_free;
  logic [WAY_W-1:0] free_way, vic_way, fill_way;
  always_comb begin
    has_free = 1'b0;
    free_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (!vld_q[fill_set][w]) begin
        has_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end
  assign fill_way = has_free ? free_way : vic_way;

  mtlb_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_en_i   (lookup_valid_i && lk_any),
    .a_set_i  (lk_set),
    .a_way_i  (lk_way),
    .b_en_i   (fill_wr),
    .b_set_i  (fill_set),
    .b_way_i  (fill_way),
    .vic_set_i(fill_set),
    .vic_way_o(vic_way)
  );

  tlb_ent_t fill_ent;
  assign fill_ent = '{sz:  pg_size_e'(fill_size_i),
                      vpn: fill_va_i[VA_W-1:PG_ORDER],
                      ppn: fill_pa_i[PA_W-1:PG_ORDER]};

  always_ff @(posedge clk_i) begin
    if (fill_wr) ent_q[fill_set][fill_way] <= fill_ent;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (flush_all_i) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      if (inv_cmd) vld_q[inv_set] <= vld_q[inv_set] & ~inv_vec;
      if (fill_wr) vld_q[fill_set][fill_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_pa_o    <= '0;
    end else begin
      resp_valid_o <= lookup_valid_i;
      resp_hit_o   <= lookup_valid_i && lk_any;
      resp_pa_o    <= make_pa(ent_q[lk_set][lk_way], lookup_va_i);
    end
  end

  // checks
  logic [SET_W-1:0] chk_fill_set_q, chk_inv_set_q;
  logic             any_vld;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_fill_set_q <= '0;
      chk_inv_set_q  <= '0;
    end else begin
      chk_fill_set_q <= fill_set;
      chk_inv_set_q  <= inv_set;
    end
  end
  always_comb begin
    any_vld = 1'b0;
    for (int s = 0; s < SETS; s++) any_vld = any_vld | (|vld_q[s]);
  end

  assert_resp_timing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> resp_valid_o == $past(lookup_valid_i));

  assert_hit_has_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_hit_o |-> resp_valid_o);

  assert_flush_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> !any_vld);

  assert_inv_clears_matches_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_cmd && !flush_all_i) |=>
      $countones(vld_q[chk_inv_set_q]) == $past($countones(vld_q[inv_set])) - $past($countones(inv_vec)));

  assert_unmarked_inv_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_i && !inv_addr_i[0] && !flush_all_i && !fill_valid_i) |=>
      $countones(vld_q[chk_inv_set_q]) == $past($countones(vld_q[inv_set])));

  assert_inv_beats_fill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && inv_cmd && inv_set == fill_set) |=>
      $countones(vld_q[chk_fill_set_q]) <= $past($countones(vld_q[fill_set])));

  assert_fill_free_way_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_wr && has_free) |=>
      $countones(vld_q[chk_fill_set_q]) == $past($countones(vld_q[fill_set])) + 1);
endmodule

// File: tb/mixed_page_tlb_tb_top.sv
`timescale 1ns/1ps
module mixed_page_tlb_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lookup_valid_i = 1'b0;
  logic [31:0] lookup_va_i = '0;
  logic        resp_valid_o, resp_hit_o;
  logic [31:0] resp_pa_o;
  logic        fill_valid_i = 1'b0;
  logic [31:0] fill_va_i = '0, fill_pa_i = '0;
  logic [1:0]  fill_size_i = '0;
  logic        flush_all_i = 1'b0;
  logic        inv_valid_i = 1'b0;
  logic [31:0] inv_addr_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  mixed_page_tlb dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lookup_valid_i(lookup_valid_i), .lookup_va_i(lookup_va_i),
    .resp_valid_o(resp_valid_o), .resp_hit_o(resp_hit_o), .resp_pa_o(resp_pa_o),
    .fill_valid_i(fill_valid_i), .fill_va_i(fill_va_i), .fill_pa_i(fill_pa_i),
    .fill_size_i(fill_size_i), .flush_all_i(flush_all_i),
    .inv_valid_i(inv_valid_i), .inv_addr_i(inv_addr_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] va, output logic hit, output logic [31:0] pa);
    @(negedge clk_i);
    lookup_valid_i = 1'b1;
    lookup_va_i    = va;
    @(negedge clk_i);
    lookup_valid_i = 1'b0;
    hit = resp_hit_o;
    pa  = resp_pa_o;
    chk("R1 resp_valid", {31'd0, resp_valid_o}, 32'd1);
  endtask

  task automatic expect_hit(input string req, input logic [31:0] va, input logic [31:0] exp_pa);
    logic h; logic [31:0] p;
    lookup(va, h, p);
    chk({req, " hit"}, {31'd0, h}, 32'd1);
    chk({req, " pa"}, p, exp_pa);
  endtask

  task automatic expect_miss(input string req, input logic [31:0] va);
    logic h; logic [31:0] p;
    lookup(va, h, p);
    chk({req, " miss"}, {31'd0, h}, 32'd0);
  endtask

  task automatic drive_fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz);
    fill_valid_i = 1'b1; fill_va_i = va; fill_pa_i = pa; fill_size_i = sz;
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz);
    @(negedge clk_i);
    drive_fill(va, pa, sz);
    @(negedge clk_i);
    fill_valid_i = 1'b0;
  endtask

  task automatic inv(input logic [31:0] addr);
    @(negedge clk_i);
    inv_valid_i = 1'b1; inv_addr_i = addr;
    @(negedge clk_i);
    inv_valid_i = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk_i);
    flush_all_i = 1'b1;
    @(negedge clk_i);
    flush_all_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 resp_valid after reset", {31'd0, resp_valid_o}, 32'd0);
    expect_miss("R1 empty after reset", 32'h0000_0000);
    expect_miss("R1 empty after reset", 32'h1234_5678);
  endtask

  task automatic t_small();
    fill(32'h1234_5000, 32'hABCD_E000, 2'd0);
    expect_hit("R2 4k", 32'h1234_5678, 32'hABCD_E678);
    expect_hit("R2 4k top offset", 32'h1234_5FFF, 32'hABCD_EFFF);
    expect_miss("R5 same set other tag", 32'h1238_5678);
    expect_miss("R2 next page", 32'h1234_6678);
  endtask

  task automatic t_large();
    logic h; logic [31:0] p;
    fill(32'h0043_2000, 32'h7770_5000, 2'd1);
    expect_hit("R3 64k", 32'h0043_2ABC, 32'h7770_2ABC);
    expect_miss("R3 64k other set", 32'h0043_3000);
    for (int k = 0; k < 16; k++) begin
      inv(32'h0043_0001 + 32'(k) * 32'h1000);
      if (k == 1) begin
        lookup(32'h0043_2ABC, h, p);
        chk("R7 partial sweep keeps entry", {31'd0, h}, 32'd1);
      end
    end
    expect_miss("R7 64k swept", 32'h0043_2ABC);
  endtask

  task automatic t_section();
    flush();
    fill(32'h056A_B000, 32'h9300_0000, 2'd2);
    expect_hit("R4 1m", 32'h056A_B123, 32'h930A_B123);
    expect_miss("R4 other section same set", 32'h057A_B123);
    inv(32'h0560_0001);
    expect_hit("R7 other set untouched", 32'h056A_B123, 32'h930A_B123);
    inv(32'h056A_B000);
    expect_hit("R8 unmarked ignored", 32'h056A_B123, 32'h930A_B123);
    inv(32'h056E_B001);
    expect_miss("R7 masked tag cleared", 32'h056A_B123);
  endtask

  task automatic t_multi();
    fill(32'h0020_3000, 32'h1111_1000, 2'd0);
    fill(32'h0020_3000, 32'h2220_0000, 2'd2);
    fill(32'h0030_3000, 32'h3333_3000, 2'd0);
    inv(32'h0020_3001);
    expect_miss("R7 all matches cleared", 32'h0020_3000);
    expect_miss("R7 section cleared", 32'h0024_3000);
    expect_hit("R7 unrelated kept", 32'h0030_3000, 32'h3333_3000);
    inv(32'h0030_3000);
    expect_hit("R8 unmarked ignored", 32'h0030_3444, 32'h3333_3444);
  endtask

  task automatic t_flush();
    fill(32'h0000_1000, 32'h4444_4000, 2'd0);
    flush();
    expect_miss("R6 flush", 32'h0000_1000);
    expect_miss("R6 flush", 32'h0030_3000);
    @(negedge clk_i);
    drive_fill(32'h0000_2000, 32'h5555_5000, 2'd0);
    flush_all_i = 1'b1;
    @(negedge clk_i);
    fill_valid_i = 1'b0; flush_all_i = 1'b0;
    expect_miss("R6 fill with flush dropped", 32'h0000_2000);
  endtask

  task automatic t_priority();
    @(negedge clk_i);
    drive_fill(32'h0000_9000, 32'h6666_6000, 2'd0);
    inv_valid_i = 1'b1; inv_addr_i = 32'h1234_9001;
    @(negedge clk_i);
    fill_valid_i = 1'b0; inv_valid_i = 1'b0;
    expect_miss("R9 same-set inv wins", 32'h0000_9000);
    @(negedge clk_i);
    drive_fill(32'h0000_A000, 32'h7777_7000, 2'd0);
    inv_valid_i = 1'b1; inv_addr_i = 32'h1234_9001;
    @(negedge clk_i);
    fill_valid_i = 1'b0; inv_valid_i = 1'b0;
    expect_hit("R9 other-set fill kept", 32'h0000_A010, 32'h7777_7010);
    fill(32'h0000_B000, 32'h8888_8000, 2'd3);
    expect_miss("R9 reserved size dropped", 32'h0000_B000);
  endtask

  task automatic t_plru();
    flush();
    for (int t = 1; t <= 8; t++) fill(32'(t) << 18, 32'(t) << 12, 2'd0);
    expect_hit("R10 touch way0", 32'h0004_0000, 32'h0000_1000);
    fill(32'(9) << 18, 32'h0000_9000, 2'd0);
    expect_miss("R10 way4 evicted", 32'(5) << 18);
    expect_hit("R10 new entry", 32'(9) << 18, 32'h0000_9000);
    expect_hit("R10 touched kept", 32'(1) << 18, 32'h0000_1000);
    expect_hit("R10 others kept", 32'(2) << 18, 32'h0000_2000);
    expect_hit("R10 others kept", 32'(8) << 18, 32'h0000_8000);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_small();
    t_large();
    t_section();
    t_multi();
    t_flush();
    t_priority();
    t_plru();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule